// File: doc/BRIEF.md
# Chip-Level Preamble Detector with Error Tolerance

This block watches the chip stream that a receiver's demodulator delivers and reports when a run of preamble has been found. The preamble consists of alternating data bits. Each bit arrives as four identical chips, so a byte of preamble spans 32 chips. A two-bit size setting selects a search window of one, two or three bytes. A five-bit tolerance sets how many chips inside the window may disagree with the ideal pattern before the match is rejected.

Chips are delivered one per cycle with a valid strobe and shift into a sliding window. Every cycle, the mismatch count is computed against both phases of the alternating pattern, and the smaller count is used. When the window is full and the count is within tolerance, the block emits a one-cycle detect pulse, which acts as the interrupt. It then waits. It re-arms when the count rises above the tolerance, or when the detector is switched off. While an AGC startup phase is active, the detector is forced off, whatever the enable says.

The control logic is a four-state machine:
- **IDLE**: the detector is off.
- **FILL**: the window is filling after an enable.
- **HUNT**: the detector is armed and searching.
- **HOLD**: a detection was reported and the detector waits to re-arm.

Transitions:
- IDLE→FILL on an effective enable.
- Any state→IDLE when the effective enable drops.
- FILL→HOLD or HUNT→HOLD when the window is full and within tolerance. This transition fires the pulse.
- FILL→HUNT when the window is full and outside tolerance.
- HOLD→HUNT when the window is full and outside tolerance.

Top module: `pd_preamble_det`

## Requirements
- R1: After reset, det_pulse is 0 and the window history is empty. No detect can occur until the window length in valid chips has been received.
- R2: While det_en is 0, det_pulse never asserts, and the fill count restarts from zero.
- R3: While agc_busy is 1, the detector is held off exactly as if det_en were 0.
- R4: size_code 2'b00, 2'b01 and 2'b10 give windows of 32, 64 and 96 chips. A detect needs at least that many valid chips since the detector last became effective.
- R5: size_code 2'b11 disables the detector.
- R6: The window position k is counted with k=0 as the newest chip. One reference expects chip value bit 2 of k. The other reference is its complement. The mismatch is the smaller of the two disagreement counts over the window.
- R7: A detect requires a full window whose mismatch is less than or equal to chip_tol (range 0 to 31).
- R8: det_pulse is high for exactly one cycle. It is high in the cycle after the clock edge that follows the edge that sampled the completing chip.
- R9: After a detect, no further pulse occurs until an evaluation of a full window sees a mismatch above chip_tol. A later match then pulses again.
- R10: Dropping the effective enable for at least one cycle re-arms the detector. The window must then refill.
- R11: chip_in is ignored in cycles where chip_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detector enable |
| agc_busy | input | 1 | AGC startup active; forces the detector off |
| size_code | input | 2 | Window size: 00=1 byte, 01=2 bytes, 10=3 bytes, 11=off |
| chip_tol | input | 5 | Number of chip mismatches tolerated |
| chip_vld | input | 1 | Chip strobe |
| chip_in | input | 1 | Chip value |
| det_pulse | output | 1 | One-cycle preamble detect interrupt |

## Verification
The window content is visible at the ports only through whether the detect pulse appears, and when. A history bit that shifts wrongly, or a fill count that is off by one, moves the pulse by a chip or suppresses it. This becomes visible within one window length of chips. A state machine stuck in HOLD shows up as missing repeat pulses on a continuous preamble with a small tolerance, since that stream should re-fire every four chips. Phase and complement errors are exposed by streams that start on either bit value.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int unsigned CHIPS_PER_BIT = 4;
    localparam int unsigned BITS_PER_BYTE = 8;
    localparam int unsigned MAX_BYTES     = 3;
    localparam int unsigned BYTE_CHIPS    = CHIPS_PER_BIT * BITS_PER_BYTE;
    localparam int unsigned MAX_CHIPS     = BYTE_CHIPS * MAX_BYTES;
    localparam int unsigned CNT_W         = $clog2(MAX_CHIPS + 1);
    localparam int unsigned TOL_W         = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_HUNT,
        ST_HOLD
    } pd_state_e;
endpackage

// File: rtl/pd_size_map.sv
module pd_size_map #(
    parameter int unsigned BYTE_CHIPS = pd_pkg::BYTE_CHIPS,
    parameter int unsigned MAX_BYTES  = pd_pkg::MAX_BYTES,
    parameter int unsigned CNT_W      = pd_pkg::CNT_W
) (
    input  logic [1:0]       size_code,
    output logic [CNT_W-1:0] win_len,
    output logic             size_ok
);
    always_comb begin
        size_ok = ({30'd0, size_code} < MAX_BYTES);
        if (size_ok) begin
            win_len = CNT_W'((int'(size_code) + 1) * BYTE_CHIPS);
        end else begin
            win_len = CNT_W'(MAX_BYTES * BYTE_CHIPS);
        end
    end
endmodule

// File: rtl/pd_chip_window.sv
module pd_chip_window #(
    parameter int unsigned MAX_CHIPS = pd_pkg::MAX_CHIPS,
    parameter int unsigned CNT_W     = pd_pkg::CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_fill,
    input  logic                 chip_vld,
    input  logic                 chip_in,
    input  logic [CNT_W-1:0]     win_len,
    output logic [MAX_CHIPS-1:0] win,
    output logic                 full
);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(MAX_CHIPS);

    logic [CNT_W-1:0] fill_q;

    // Newest chip enters at bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (chip_vld) begin
            win <= {win[MAX_CHIPS-2:0], chip_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clr_fill) begin
            fill_q <= '0;
        end else if (chip_vld && (fill_q != FILL_MAX)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign full = (fill_q >= win_len);
endmodule

// File: rtl/pd_mismatch.sv
module pd_mismatch #(
    parameter int unsigned MAX_CHIPS = pd_pkg::MAX_CHIPS,
    parameter int unsigned RUN_LEN   = pd_pkg::CHIPS_PER_BIT,
    parameter int unsigned CNT_W     = pd_pkg::CNT_W
) (
    input  logic [MAX_CHIPS-1:0] win,
    input  logic [CNT_W-1:0]     win_len,
    output logic [CNT_W-1:0]     mism
);
    logic [MAX_CHIPS-1:0] diff;
    logic [CNT_W-1:0]     cnt_a;
    logic [CNT_W-1:0]     cnt_b;

    for (genvar k = 0; k < MAX_CHIPS; k++) begin : g_pos
        localparam logic REF_BIT = ((k / RUN_LEN) % 2) != 0;
        assign diff[k] = (win[k] ^ REF_BIT) & (CNT_W'(k) < win_len);
    end

    always_comb begin
        cnt_a = '0;
        for (int i = 0; i < MAX_CHIPS; i++) begin
            cnt_a = cnt_a + CNT_W'(diff[i]);
        end
        cnt_b = win_len - cnt_a;
        mism  = (cnt_a < cnt_b) ? cnt_a : cnt_b;
    end
endmodule

// File: rtl/pd_preamble_det.sv
module pd_preamble_det #(
    parameter int unsigned CHIPS_PER_BIT = pd_pkg::CHIPS_PER_BIT,
    parameter int unsigned BYTE_CHIPS    = pd_pkg::BYTE_CHIPS,
    parameter int unsigned MAX_BYTES     = pd_pkg::MAX_BYTES,
    parameter int unsigned TOL_W         = pd_pkg::TOL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             agc_busy,
    input  logic [1:0]       size_code,
    input  logic [TOL_W-1:0] chip_tol,
    input  logic             chip_vld,
    input  logic             chip_in,
    output logic             det_pulse
);
    import pd_pkg::*;

    localparam int unsigned N_CHIPS = BYTE_CHIPS * MAX_BYTES;
    localparam int unsigned CW      = $clog2(N_CHIPS + 1);

    pd_state_e          state_q, state_d;
    logic [CW-1:0]      win_len;
    logic               size_ok;
    logic               eff_en;
    logic [N_CHIPS-1:0] win;
    logic               win_full;
    logic [CW-1:0]      mism_cnt;
    logic               in_tol;
    logic               fire;

    pd_size_map #(
        .BYTE_CHIPS(BYTE_CHIPS),
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CW)
    ) u_size (
        .size_code(size_code),
        .win_len  (win_len),
        .size_ok  (size_ok)
    );

    assign eff_en = det_en & ~agc_busy & size_ok;

    pd_chip_window #(
        .MAX_CHIPS(N_CHIPS),
        .CNT_W    (CW)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_fill(~eff_en),
        .chip_vld(chip_vld),
        .chip_in (chip_in),
        .win_len (win_len),
        .win     (win),
        .full    (win_full)
    );

    pd_mismatch #(
        .MAX_CHIPS(N_CHIPS),
        .RUN_LEN  (CHIPS_PER_BIT),
        .CNT_W    (CW)
    ) u_cmp (
        .win    (win),
        .win_len(win_len),
        .mism   (mism_cnt)
    );

    assign in_tol = (mism_cnt <= CW'(chip_tol));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (eff_en) state_d = ST_FILL;
            end
            ST_FILL, ST_HUNT: begin
                if (!eff_en) begin
                    state_d = ST_IDLE;
                end else if (win_full && in_tol) begin
                    state_d = ST_HOLD;
                    fire    = 1'b1;
                end else if (win_full) begin
                    state_d = ST_HUNT;
                end
            end
            ST_HOLD: begin
                if (!eff_en) begin
                    state_d = ST_IDLE;
                end else if (win_full && !in_tol) begin
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_pulse <= 1'b0;
        end else begin
            det_pulse <= fire;
        end
    end
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
    parameter int unsigned CNT_W = pd_pkg::CNT_W,
    parameter int unsigned TOL_W = pd_pkg::TOL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_en,
    input logic             agc_busy,
    input logic [1:0]       size_code,
    input logic [TOL_W-1:0] chip_tol,
    input logic             win_full,
    input logic [CNT_W-1:0] mism_cnt,
    input logic             det_pulse
);
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);

    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(det_en));

    a_r3_agc_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> !$past(agc_busy));

    a_r5_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> ($past(size_code) != 2'b11));

    a_r4_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(win_full));

    a_r7_within_tol: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> ($past(mism_cnt) <= CNT_W'($past(chip_tol))));
endmodule

bind pd_preamble_det pd_checker #(
    .CNT_W(CW),
    .TOL_W(TOL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_en   (det_en),
    .agc_busy (agc_busy),
    .size_code(size_code),
    .chip_tol (chip_tol),
    .win_full (win_full),
    .mism_cnt (mism_cnt),
    .det_pulse(det_pulse)
);

// File: tb/test_pd_preamble_det.sv
`timescale 1ns/1ps
module test_pd_preamble_det;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_en = 1'b0;
    logic       agc_busy = 1'b0;
    logic [1:0] size_code = 2'b00;
    logic [4:0] chip_tol = 5'd0;
    logic       chip_vld = 1'b0;
    logic       chip_in = 1'b0;
    logic       det_pulse;

    // configuration applied at the next falling edge
    logic       cfg_en = 1'b0, cfg_agc = 1'b0;
    logic [1:0] cfg_size = 2'b00;
    logic [4:0] cfg_tol = 5'd0;

    int checks = 0, failures = 0, pulse_cnt = 0;
    string cur_req = "R1";
    bit exp_q[$];
    bit done = 0;

    // reference state
    logic [95:0] m_hist = '0;
    int m_fill = 0;
    bit m_armed = 1;

    always #2.5 clk = ~clk;

    pd_preamble_det i_pd_preamble_det (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .agc_busy(agc_busy),
        .size_code(size_code), .chip_tol(chip_tol), .chip_vld(chip_vld),
        .chip_in(chip_in), .det_pulse(det_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_mism(input int n);
        int ca = 0;
        for (int k = 0; k < n; k++) begin
            if (m_hist[k] != ((k / 4) % 2 == 1)) ca++;
        end
        return (ca < n - ca) ? ca : n - ca;
    endfunction

    // Reference model, evaluated at each rising edge with the sampled inputs.
    task automatic model_edge();
        bit exp = 0;
        bit eff;
        int n;
        if (!rst_n) begin
            m_hist = '0; m_fill = 0; m_armed = 1;
        end else begin
            eff = det_en && !agc_busy && (size_code != 2'b11);
            n = (int'(size_code) + 1) * 32;
            if (!eff) begin
                m_armed = 1; m_fill = 0;
            end else if (m_fill >= n) begin
                if (ref_mism(n) <= int'(chip_tol)) begin
                    if (m_armed) exp = 1;
                    m_armed = 0;
                end else begin
                    m_armed = 1;
                end
            end
            if (chip_vld) begin
                m_hist = {m_hist[94:0], chip_in};
                if (eff && m_fill < 96) m_fill++;
            end
        end
        exp_q.push_back(exp);
    endtask

    task automatic step(input bit vld, input bit c);
        @(negedge clk);
        det_en = cfg_en; agc_busy = cfg_agc; size_code = cfg_size; chip_tol = cfg_tol;
        chip_vld = vld; chip_in = c;
        @(posedge clk);
        model_edge();
    endtask

    task automatic send_pre(input int start, input int n, input bit inv,
                            input int fa, input int fb, input int fc);
        for (int i = start; i < start + n; i++) begin
            step(1'b1, (((i / 4) % 2) == 1) ^ inv ^ (i == fa || i == fb || i == fc));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic expect_pulses(input int exp, input string req);
        idle(3);
        check(pulse_cnt == exp, req, pulse_cnt, exp);
        pulse_cnt = 0;
    endtask

    task automatic toggle_off();
        cfg_en = 1'b0;
        idle(2);
        cfg_en = 1'b1;
    endtask

    // monitor: scoreboard compare
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                bit e;
                e = exp_q.pop_front();
                check(det_pulse == e, cur_req, det_pulse, e);
                if (det_pulse) pulse_cnt++;
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) step(1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        check(det_pulse == 1'b0, "R1", det_pulse, 0);

        // R1 / R4: needs a full 32-chip window
        cur_req = "R1"; cfg_en = 1; cfg_size = 2'b00; cfg_tol = 0;
        send_pre(0, 31, 0, -1, -1, -1);
        expect_pulses(0, "R1");
        cur_req = "R4";
        send_pre(31, 1, 0, -1, -1, -1);
        expect_pulses(1, "R4");

        // R6: complementary phase, two-byte window
        cur_req = "R6"; toggle_off(); cfg_size = 2'b01;
        send_pre(0, 64, 1, -1, -1, -1);
        expect_pulses(1, "R6");

        // R7: three errors with tolerance 3 in a 96-chip window
        cur_req = "R7"; toggle_off(); cfg_size = 2'b10; cfg_tol = 3;
        send_pre(0, 96, 0, 5, 40, 90);
        expect_pulses(1, "R7");

        // R7: same errors with tolerance 2
        toggle_off(); cfg_tol = 2;
        send_pre(0, 96, 0, 5, 40, 90);
        expect_pulses(0, "R7");

        // R9: tolerance 16 never exceeded on a continuous preamble
        cur_req = "R9"; toggle_off(); cfg_size = 2'b00; cfg_tol = 16;
        send_pre(0, 64, 0, -1, -1, -1);
        expect_pulses(1, "R9");

        // R9: tolerance 4 re-arms at odd offsets, pulses every 4 chips
        toggle_off(); cfg_tol = 4;
        send_pre(0, 64, 0, -1, -1, -1);
        expect_pulses(9, "R9");

        // R2: disabled
        cur_req = "R2"; cfg_en = 0; cfg_tol = 0;
        send_pre(0, 40, 0, -1, -1, -1);
        expect_pulses(0, "R2");

        // R3: AGC override
        cur_req = "R3"; cfg_en = 1; cfg_agc = 1;
        send_pre(0, 40, 0, -1, -1, -1);
        expect_pulses(0, "R3");
        cfg_agc = 0;

        // R5: reserved size code
        cur_req = "R5"; cfg_size = 2'b11;
        send_pre(0, 100, 0, -1, -1, -1);
        expect_pulses(0, "R5");

        // R10: enable drop re-arms
        cur_req = "R10"; cfg_size = 2'b00; cfg_tol = 16; toggle_off();
        send_pre(0, 32, 0, -1, -1, -1);
        expect_pulses(1, "R10");
        toggle_off();
        send_pre(0, 32, 0, -1, -1, -1);
        expect_pulses(1, "R10");

        // R11: invalid cycles carry garbage
        cur_req = "R11"; cfg_tol = 0; toggle_off();
        for (int i = 0; i < 32; i++) begin
            step(1'b1, ((i / 4) % 2) == 1);
            step(1'b0, ((i / 4) % 2) == 0);
        end
        expect_pulses(1, "R11");

        // R8: pulse width verified per cycle by scoreboard; queue drained
        cur_req = "R8";
        idle(2);
        @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule